// File: doc/BRIEF.md
# LIN Message Buffer Sequencer

This block owns an eight-byte message buffer and moves it between a host and the byte-level serial channel of a LIN node. It handles both directions. Long, extended frames are cut into chunks of up to eight bytes. A chunk marked final is closed with the frame checksum. A chunk not marked final stops after its data and raises its own completion event. The running checksum carries across every chunk of a frame and starts again at the first chunk after a final chunk or an abort.

To transmit, the host writes the buffer while the sequencer is idle. It then pulses `tx_start` with the chunk length, the final flag and the checksum mode. The sequencer hands the bytes to a byte serializer with a valid/ready handshake, and then sends the inverted checksum if the chunk is final. On receive, the first byte that arrives from the byte deserializer while the sequencer is idle opens a chunk. The same length, final and mode inputs apply to it. The incoming bytes fill the buffer, and a final chunk has its trailing checksum checked. The buffer then stays locked until the host reads byte 0. Bit-level UART timing belongs to the serializer and deserializer and is outside this block.

Top module: `lin_msgbuf_seq`

## Requirements
- R1: On `tx_start` in idle, the sequencer presents buffer bytes 0 up to `chunk_len_m1` (byte count = `chunk_len_m1`+1) in order on `ser_data` with `ser_valid` high. A byte advances only on a cycle with `ser_valid` and `ser_ready` both high, and `ser_data` holds steady while `ser_ready` is low. At most one event output is high in any cycle.
- R2: When `chunk_final`=1 at start, the last data byte is followed by one checksum byte. `ev_tx_cks` pulses for one cycle, in the cycle after the checksum byte is accepted.
- R3: When `chunk_final`=0 at start, no checksum byte is sent. `ev_tx_nocks` pulses in the cycle after the last data byte is accepted, and `ser_valid` is low in that cycle.
- R4: The checksum byte is the bitwise inverse of an 8-bit sum in which every carry out of bit 7 is added back in. The sum covers all data bytes of every chunk since the frame started. With `cks_enh`=1 at the first chunk, it also includes `prot_id`. With `cks_enh`=0 it covers the data only.
- R5: In idle, a byte arriving on the deserializer starts a receive chunk. Its bytes are stored at buffer indices 0 upward. A non-final chunk pulses `ev_rx_nocks` in the cycle after its last byte, and the bytes can be read on `host_rdata` at `host_rd_idx`.
- R6: For a final receive chunk, the byte after the data is compared with the checksum of R4. A match pulses `ev_rx_ok`. A mismatch pulses `ev_cks_err`.
- R7: After a receive chunk completes, the buffer stays full until a cycle with `host_rd_en`=1 and `host_rd_idx`=0. A byte that arrives while the buffer is full is not stored, and `ev_overrun` pulses in the next cycle.
- R8: `tx_abort` during a transmit chunk returns the sequencer to idle at once: `ser_valid` is low in the next cycle and no transmit event is raised. The next chunk starts a new frame checksum.
- R9: Host writes are ignored unless the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Start a transmit chunk (sampled in idle) |
| tx_abort | input | 1 | Abandon the transmit chunk in progress |
| chunk_len_m1 | input | IDX_W | Chunk byte count minus one |
| chunk_final | input | 1 | 1: chunk closes the frame with a checksum |
| cks_enh | input | 1 | 1: identifier included in checksum |
| prot_id | input | 8 | Protected identifier for enhanced checksum |
| host_we | input | 1 | Host buffer write strobe |
| host_idx | input | IDX_W | Host write index |
| host_wdata | input | 8 | Host write data |
| host_rd_idx | input | IDX_W | Host read index |
| host_rd_en | input | 1 | Host read strobe (index 0 releases a full buffer) |
| host_rdata | output | 8 | Buffer byte at `host_rd_idx` |
| ser_valid | output | 1 | Byte offered to the serializer |
| ser_ready | input | 1 | Serializer takes the byte |
| ser_data | output | 8 | Byte to the serializer |
| des_valid | input | 1 | Deserializer delivers a byte this cycle |
| des_data | input | 8 | Received byte |
| ev_tx_cks | output | 1 | Transmit chunk sent with checksum |
| ev_tx_nocks | output | 1 | Transmit chunk sent without checksum |
| ev_rx_ok | output | 1 | Final receive chunk, checksum matched |
| ev_rx_nocks | output | 1 | Intermediate receive chunk complete |
| ev_cks_err | output | 1 | Final receive chunk, checksum mismatch |
| ev_overrun | output | 1 | Byte arrived while the buffer was full |

## Verification
The assertions check the following on every cycle: no more than one event fires at a time, the serializer byte holds steady through a stall, a non-final transmit chunk ends with its event and with no checksum byte offered, a received checksum byte always produces either the OK event or the error event, an overrun comes only from a full buffer, and an abort never produces a transmit event. Other properties depend on the actual data values, so only the bench scenarios can show them. These are the byte order and checksum value across a two-chunk enhanced frame, the fresh checksum seed after an abort, the buffer contents after a receive, and the fact that a full buffer keeps its data against both an overrunning byte and a host write.

// File: rtl/lin_seq_pkg.sv
// Shared types and the checksum helper of the LIN message buffer sequencer.
// Assumes 8-bit bytes; the checksum sum folds the carry back into bit 0.
package lin_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TX_DATA,
        ST_TX_CKS,
        ST_RX_DATA,
        ST_RX_CKS,
        ST_RX_FULL
    } seq_state_t;

    // Add two bytes and feed the carry out of bit 7 back in.
    function automatic logic [7:0] cks_add(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[7:0] + {7'd0, s[8]};
    endfunction

endpackage

// File: rtl/lin_msg_buf.sv
// Message byte storage: one register per byte, two write sources, two read taps.
// Assumes the receive write has priority and that host writes are refused while
// the sequencer is busy (host_block).
module lin_msg_buf #(
    parameter int BUF_BYTES = 8,
    localparam int IDX_W = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [7:0]       host_data,
    input  logic             host_block,
    input  logic             rx_we,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic [7:0]       rx_data,
    input  logic [IDX_W-1:0] tx_idx,
    output logic [7:0]       tx_byte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);

    logic [7:0] mem [BUF_BYTES];

    for (genvar g = 0; g < BUF_BYTES; g++) begin : g_byte
        // Byte register g: receive data first, then host data when allowed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= 8'h00;
            end else if (rx_we && rx_idx == IDX_W'(g)) begin
                mem[g] <= rx_data;
            end else if (host_we && !host_block && host_idx == IDX_W'(g)) begin
                mem[g] <= host_data;
            end
        end
    end

    // Read taps for the transmit path and the host.
    always_comb begin
        tx_byte = mem[tx_idx];
        rd_byte = mem[rd_idx];
    end

endmodule

// File: rtl/lin_cks_unit.sv
// Running frame checksum accumulator.
// Assumes a seed and an addition may coincide; the addition then applies to the seed.
module lin_cks_unit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed_en,
    input  logic [7:0] seed_val,
    input  logic       add_en,
    input  logic [7:0] add_val,
    output logic [7:0] sum
);
    import lin_seq_pkg::*;

    logic [7:0] base;
    logic [7:0] sum_nxt;

    // Choose the starting point and fold in the new byte.
    always_comb begin
        base    = seed_en ? seed_val : sum;
        sum_nxt = add_en ? cks_add(base, add_val) : base;
    end

    // Hold the accumulated sum.
    always_ff @(posedge clk) begin
        if (!rst_n) sum <= 8'h00;
        else        sum <= sum_nxt;
    end

endmodule

// File: rtl/lin_seq_ctrl.sv
// Chunk sequencer: walks the transmit and receive chunks, steers the buffer and
// checksum, and raises one-cycle completion and error events.
// Assumes chunk parameters are stable in the cycle a chunk opens; they are latched then.
module lin_seq_ctrl #(
    parameter int BUF_BYTES = 8,
    localparam int IDX_W = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_start,
    input  logic             tx_abort,
    input  logic [IDX_W-1:0] len_m1,
    input  logic             final_in,
    input  logic             enh_in,
    input  logic [7:0]       prot_id,
    input  logic             ser_ready,
    input  logic             des_valid,
    input  logic [7:0]       des_data,
    input  logic             release_req,
    input  logic [7:0]       tx_byte,
    input  logic [7:0]       sum,
    output logic             ser_valid,
    output logic             sel_cks,
    output logic [IDX_W-1:0] tx_idx,
    output logic             rx_we,
    output logic [IDX_W-1:0] rx_idx,
    output logic             seed_en,
    output logic [7:0]       seed_val,
    output logic             add_en,
    output logic [7:0]       add_val,
    output logic             host_block,
    output logic             ev_tx_cks,
    output logic             ev_tx_nocks,
    output logic             ev_rx_ok,
    output logic             ev_rx_nocks,
    output logic             ev_cks_err,
    output logic             ev_overrun
);
    import lin_seq_pkg::*;

    seq_state_t       state;
    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] len_q;
    logic             fin_q;
    logic             in_frame;

    logic             tx_go, rx_first, tx_xfer, rx_take, rx_last;
    logic [IDX_W-1:0] cur_len;

    // Decode this cycle's transfers and the buffer/checksum steering.
    always_comb begin
        cur_len    = (state == ST_IDLE) ? len_m1 : len_q;
        tx_go      = (state == ST_IDLE) && tx_start;
        rx_first   = (state == ST_IDLE) && !tx_start && des_valid;
        ser_valid  = (state == ST_TX_DATA) || (state == ST_TX_CKS);
        sel_cks    = (state == ST_TX_CKS);
        tx_idx     = cnt;
        tx_xfer    = (state == ST_TX_DATA) && ser_ready && !tx_abort;
        rx_take    = rx_first || ((state == ST_RX_DATA) && des_valid);
        rx_idx     = (state == ST_IDLE) ? '0 : cnt;
        rx_last    = (rx_idx == cur_len);
        rx_we      = rx_take;
        seed_en    = (tx_go || rx_first) && !in_frame;
        seed_val   = enh_in ? prot_id : 8'h00;
        add_en     = tx_xfer || rx_take;
        add_val    = tx_xfer ? tx_byte : des_data;
        host_block = (state != ST_IDLE);
    end

    // State, counters, frame tracking and registered event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            len_q       <= '0;
            fin_q       <= 1'b0;
            in_frame    <= 1'b0;
            ev_tx_cks   <= 1'b0;
            ev_tx_nocks <= 1'b0;
            ev_rx_ok    <= 1'b0;
            ev_rx_nocks <= 1'b0;
            ev_cks_err  <= 1'b0;
            ev_overrun  <= 1'b0;
        end else begin
            ev_tx_cks   <= 1'b0;
            ev_tx_nocks <= 1'b0;
            ev_rx_ok    <= 1'b0;
            ev_rx_nocks <= 1'b0;
            ev_cks_err  <= 1'b0;
            ev_overrun  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tx_go) begin
                        len_q    <= len_m1;
                        fin_q    <= final_in;
                        cnt      <= '0;
                        in_frame <= 1'b1;
                        state    <= ST_TX_DATA;
                    end else if (rx_first) begin
                        len_q    <= len_m1;
                        fin_q    <= final_in;
                        in_frame <= 1'b1;
                        if (rx_last) begin
                            if (final_in) begin
                                state <= ST_RX_CKS;
                            end else begin
                                state       <= ST_RX_FULL;
                                ev_rx_nocks <= 1'b1;
                            end
                        end else begin
                            cnt   <= IDX_W'(1);
                            state <= ST_RX_DATA;
                        end
                    end
                end
                ST_TX_DATA: begin
                    if (tx_abort) begin
                        in_frame <= 1'b0;
                        state    <= ST_IDLE;
                    end else if (ser_ready) begin
                        if (cnt == len_q) begin
                            if (fin_q) begin
                                state <= ST_TX_CKS;
                            end else begin
                                ev_tx_nocks <= 1'b1;
                                state       <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_TX_CKS: begin
                    if (tx_abort) begin
                        in_frame <= 1'b0;
                        state    <= ST_IDLE;
                    end else if (ser_ready) begin
                        ev_tx_cks <= 1'b1;
                        in_frame  <= 1'b0;
                        state     <= ST_IDLE;
                    end
                end
                ST_RX_DATA: begin
                    if (des_valid) begin
                        if (rx_last) begin
                            if (fin_q) begin
                                state <= ST_RX_CKS;
                            end else begin
                                ev_rx_nocks <= 1'b1;
                                state       <= ST_RX_FULL;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_RX_CKS: begin
                    if (des_valid) begin
                        if (des_data == ~sum) ev_rx_ok   <= 1'b1;
                        else                  ev_cks_err <= 1'b1;
                        in_frame <= 1'b0;
                        state    <= ST_RX_FULL;
                    end
                end
                ST_RX_FULL: begin
                    if (des_valid)   ev_overrun <= 1'b1;
                    if (release_req) state      <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: the events are mutually exclusive.
    a_r1_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_tx_cks, ev_tx_nocks, ev_rx_ok, ev_rx_nocks, ev_cks_err, ev_overrun}));

    // R3: a non-final chunk ends on its last byte with no checksum byte offered.
    a_r3_nocks_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_DATA && ser_ready && !tx_abort && cnt == len_q && !fin_q)
        |=> (ev_tx_nocks && !ser_valid));

    // R6: a received checksum byte always yields a verdict.
    a_r6_cks_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RX_CKS && des_valid) |=> (ev_rx_ok || ev_cks_err));

    // R7: an overrun only follows a byte that hit a full buffer.
    a_r7_overrun_full: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overrun |-> ($past(state) == ST_RX_FULL && $past(des_valid)));

    // R8: an abort never produces a transmit completion.
    a_r8_abort_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && tx_abort) |=> (!ev_tx_cks && !ev_tx_nocks && !ser_valid));

endmodule

// File: rtl/lin_msgbuf_seq.sv
// Top of the LIN message buffer sequencer: buffer, checksum accumulator and
// chunk controller. The transmit checksum byte is the inverted running sum.
// Assumes the serializer and deserializer carry whole bytes.
module lin_msgbuf_seq #(
    parameter int BUF_BYTES = 8,
    localparam int IDX_W = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_start,
    input  logic             tx_abort,
    input  logic [IDX_W-1:0] chunk_len_m1,
    input  logic             chunk_final,
    input  logic             cks_enh,
    input  logic [7:0]       prot_id,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [7:0]       host_wdata,
    input  logic [IDX_W-1:0] host_rd_idx,
    input  logic             host_rd_en,
    output logic [7:0]       host_rdata,
    output logic             ser_valid,
    input  logic             ser_ready,
    output logic [7:0]       ser_data,
    input  logic             des_valid,
    input  logic [7:0]       des_data,
    output logic             ev_tx_cks,
    output logic             ev_tx_nocks,
    output logic             ev_rx_ok,
    output logic             ev_rx_nocks,
    output logic             ev_cks_err,
    output logic             ev_overrun
);

    logic             sel_cks, rx_we, seed_en, add_en, host_block, release_req;
    logic [IDX_W-1:0] tx_idx, rx_idx;
    logic [7:0]       tx_byte, seed_val, add_val, sum;

    // A read strobe at byte 0 is the release request for a full buffer.
    always_comb begin
        release_req = host_rd_en && (host_rd_idx == '0);
        ser_data    = sel_cks ? ~sum : tx_byte;
    end

    lin_msg_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_idx   (host_idx),
        .host_data  (host_wdata),
        .host_block (host_block),
        .rx_we      (rx_we),
        .rx_idx     (rx_idx),
        .rx_data    (des_data),
        .tx_idx     (tx_idx),
        .tx_byte    (tx_byte),
        .rd_idx     (host_rd_idx),
        .rd_byte    (host_rdata)
    );

    lin_cks_unit u_cks (
        .clk      (clk),
        .rst_n    (rst_n),
        .seed_en  (seed_en),
        .seed_val (seed_val),
        .add_en   (add_en),
        .add_val  (add_val),
        .sum      (sum)
    );

    lin_seq_ctrl #(.BUF_BYTES(BUF_BYTES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_start    (tx_start),
        .tx_abort    (tx_abort),
        .len_m1      (chunk_len_m1),
        .final_in    (chunk_final),
        .enh_in      (cks_enh),
        .prot_id     (prot_id),
        .ser_ready   (ser_ready),
        .des_valid   (des_valid),
        .des_data    (des_data),
        .release_req (release_req),
        .tx_byte     (tx_byte),
        .sum         (sum),
        .ser_valid   (ser_valid),
        .sel_cks     (sel_cks),
        .tx_idx      (tx_idx),
        .rx_we       (rx_we),
        .rx_idx      (rx_idx),
        .seed_en     (seed_en),
        .seed_val    (seed_val),
        .add_en      (add_en),
        .add_val     (add_val),
        .host_block  (host_block),
        .ev_tx_cks   (ev_tx_cks),
        .ev_tx_nocks (ev_tx_nocks),
        .ev_rx_ok    (ev_rx_ok),
        .ev_rx_nocks (ev_rx_nocks),
        .ev_cks_err  (ev_cks_err),
        .ev_overrun  (ev_overrun)
    );

    // R1: a stalled byte stays on offer unchanged.
    a_r1_ser_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !ser_ready && !tx_abort) |=> (ser_valid && $stable(ser_data)));

endmodule

// File: tb/sim_lin_msgbuf_seq.sv
// Scoreboard bench: the drivers queue the expected serializer bytes, and a monitor
// pops and compares them, and counts event pulses. Inputs change at the falling
// edge; the monitor samples 2 time units later.
module sim_lin_msgbuf_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int IW = $clog2(NB);

    logic          clk = 0, rst_n = 0;
    logic          tx_start = 0, tx_abort = 0, chunk_final = 0, cks_enh = 0;
    logic [IW-1:0] chunk_len_m1 = '0, host_idx = '0, host_rd_idx = '0;
    logic [7:0]    prot_id = 0, host_wdata = 0, des_data = 0;
    logic          host_we = 0, host_rd_en = 0, des_valid = 0, ready_en = 0;
    logic [7:0]    host_rdata, ser_data;
    logic          ser_valid, ser_ready;
    logic          ev_tx_cks, ev_tx_nocks, ev_rx_ok, ev_rx_nocks, ev_cks_err, ev_overrun;
    logic [1:0]    stall_cnt = 0;

    int checks = 0, errors = 0, xfers = 0;
    int evc[6];
    int base[6];
    logic [7:0] exp_q[$];
    logic [7:0] run_sum;

    assign ser_ready = ready_en && (stall_cnt != 2'd3);

    lin_msgbuf_seq #(.BUF_BYTES(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_abort(tx_abort),
        .chunk_len_m1(chunk_len_m1), .chunk_final(chunk_final), .cks_enh(cks_enh),
        .prot_id(prot_id), .host_we(host_we), .host_idx(host_idx),
        .host_wdata(host_wdata), .host_rd_idx(host_rd_idx), .host_rd_en(host_rd_en),
        .host_rdata(host_rdata), .ser_valid(ser_valid), .ser_ready(ser_ready),
        .ser_data(ser_data), .des_valid(des_valid), .des_data(des_data),
        .ev_tx_cks(ev_tx_cks), .ev_tx_nocks(ev_tx_nocks), .ev_rx_ok(ev_rx_ok),
        .ev_rx_nocks(ev_rx_nocks), .ev_cks_err(ev_cks_err), .ev_overrun(ev_overrun));

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) stall_cnt <= stall_cnt + 2'd1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference checksum step from R4: the carry is added back in.
    function automatic logic [7:0] ref_add(input logic [7:0] a, input logic [7:0] b);
        int s;
        s = int'(a) + int'(b);
        if (s > 255) s = s - 255;
        return 8'(s);
    endfunction

    // Monitor: scoreboard for serializer bytes and counters for event pulses.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (ser_valid && ser_ready) begin
                    xfers++;
                    if (exp_q.size() == 0) check("R1 unexpected byte", ser_data, 0);
                    else check("R1/R2/R4 ser byte", ser_data, exp_q.pop_front());
                end
                if (ev_tx_cks)   evc[0]++;
                if (ev_tx_nocks) evc[1]++;
                if (ev_rx_ok)    evc[2]++;
                if (ev_rx_nocks) evc[3]++;
                if (ev_cks_err)  evc[4]++;
                if (ev_overrun)  evc[5]++;
            end
        end
    end

    task automatic snap();
        for (int i = 0; i < 6; i++) base[i] = evc[i];
    endtask

    task automatic check_ev(input string tag, input int e0, input int e1, input int e2,
                            input int e3, input int e4, input int e5);
        int ex[6];
        ex = '{e0, e1, e2, e3, e4, e5};
        for (int i = 0; i < 6; i++) check($sformatf("%s event %0d", tag, i), evc[i] - base[i], ex[i]);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwrite(input int idx, input logic [7:0] d);
        @(negedge clk);
        host_we = 1; host_idx = IW'(idx); host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    // Load a chunk, queue its bytes (and checksum if final), start it.
    task automatic tx_chunk(input logic [7:0] d[], input bit fin, input bit enh, input bit first);
        if (first) run_sum = enh ? prot_id : 8'h00;
        for (int i = 0; i < d.size(); i++) begin
            hwrite(i, d[i]);
            exp_q.push_back(d[i]);
            run_sum = ref_add(run_sum, d[i]);
        end
        if (fin) exp_q.push_back(~run_sum);
        @(negedge clk);
        tx_start = 1; chunk_len_m1 = IW'(d.size() - 1); chunk_final = fin; cks_enh = enh;
        @(negedge clk);
        tx_start = 0;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        wait_cyc(2);
    endtask

    task automatic rx_byte(input logic [7:0] b);
        @(negedge clk);
        des_valid = 1; des_data = b;
        @(negedge clk);
        des_valid = 0;
    endtask

    task automatic rx_cfg(input int n, input bit fin, input bit enh);
        chunk_len_m1 = IW'(n - 1); chunk_final = fin; cks_enh = enh;
    endtask

    task automatic read_chk(input string tag, input int idx, input logic [7:0] exp);
        @(negedge clk);
        host_rd_idx = IW'(idx);
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic release_buf();
        @(negedge clk);
        host_rd_idx = '0; host_rd_en = 1;
        @(negedge clk);
        host_rd_en = 0;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] c1[], c2[];
        logic [7:0] s;
        wait_cyc(3);
        rst_n = 1;
        @(negedge clk); #2;
        check("R1 reset ser_valid", ser_valid, 0);
        check("R1 reset events", {ev_tx_cks, ev_tx_nocks, ev_rx_ok, ev_rx_nocks, ev_cks_err, ev_overrun}, 0);
        ready_en = 1;

        // R2, R4: classic single chunk with stalls.
        snap();
        tx_chunk('{8'h11, 8'h22, 8'h33, 8'h44}, 1, 0, 1);
        wait_drain();
        check("R2 queue drained", exp_q.size(), 0);
        check_ev("R2", 1, 0, 0, 0, 0, 0);

        // R3, R4: enhanced two-chunk frame, the sum carries across the chunks.
        prot_id = 8'h50;
        snap();
        c1 = new[8];
        for (int i = 0; i < 8; i++) c1[i] = 8'(8'h80 + i * 8'h13);
        tx_chunk(c1, 0, 1, 1);
        wait_drain();
        check("R3 no checksum queued", exp_q.size(), 0);
        check_ev("R3", 0, 1, 0, 0, 0, 0);
        snap();
        tx_chunk('{8'hFE, 8'h01, 8'hC3}, 1, 1, 0);
        wait_drain();
        check_ev("R4 enhanced final", 1, 0, 0, 0, 0, 0);

        // R8: abort after two bytes, then a fresh frame.
        snap();
        for (int i = 0; i < 5; i++) hwrite(i, 8'(8'hA0 + i));
        exp_q.push_back(8'hA0); exp_q.push_back(8'hA1);
        @(negedge clk);
        tx_start = 1; chunk_len_m1 = IW'(4); chunk_final = 1; cks_enh = 0;
        @(negedge clk);
        tx_start = 0;
        for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
        ready_en = 0; tx_abort = 1;
        @(negedge clk);
        tx_abort = 0;
        #2;
        check("R8 ser_valid after abort", ser_valid, 0);
        ready_en = 1;
        wait_cyc(5);
        check_ev("R8 no event", 0, 0, 0, 0, 0, 0);
        snap();
        tx_chunk('{8'hF0}, 1, 0, 1);
        wait_drain();
        check_ev("R8 fresh frame", 1, 0, 0, 0, 0, 0);

        // R5: intermediate receive chunk, enhanced.
        prot_id = 8'h3C;
        snap();
        rx_cfg(8, 0, 1);
        s = 8'h3C;
        for (int i = 0; i < 8; i++) begin
            rx_byte(8'(8'h21 * (i + 1)));
            s = ref_add(s, 8'(8'h21 * (i + 1)));
        end
        wait_cyc(1);
        check_ev("R5", 0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 8; i++) read_chk("R5 rx byte", i, 8'(8'h21 * (i + 1)));

        // R7, R9: overrun and host write while full change nothing.
        snap();
        rx_byte(8'hEE);
        wait_cyc(1);
        check_ev("R7 overrun", 0, 0, 0, 0, 0, 1);
        read_chk("R7 byte0 kept", 0, 8'h21);
        hwrite(1, 8'h99);
        read_chk("R9 write ignored", 1, 8'h42);
        release_buf();

        // R6: final receive chunk with a matching checksum.
        snap();
        rx_cfg(2, 1, 1);
        rx_byte(8'h07); s = ref_add(s, 8'h07);
        rx_byte(8'hF9); s = ref_add(s, 8'hF9);
        rx_byte(~s);
        wait_cyc(1);
        check_ev("R6 ok", 0, 0, 1, 0, 0, 0);
        read_chk("R6 rx byte1", 1, 8'hF9);
        release_buf();

        // R6: new classic frame with a wrong checksum.
        snap();
        rx_cfg(1, 1, 0);
        rx_byte(8'h07);
        rx_byte(8'h07);
        wait_cyc(1);
        check_ev("R6 error", 0, 0, 0, 0, 1, 0);
        release_buf();

        // R9: host writes work again once idle.
        hwrite(2, 8'h5A);
        read_chk("R9 idle write", 2, 8'h5A);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule